// File: doc/BRIEF.md
# PLL Multiplier Shift-Register Codec

This block translates a PLL feedback multiplier between its plain binary value and the 17-bit shift-register code that the PLL's multiplier field expects. It also works the other way, recovering the binary multiplier from a code. In both directions it derives the two loop-bandwidth settings, proportional and integral, from the multiplier. It packs them with the code into one configuration word that can be written to the PLL as it stands. With pre- and post-division left at one, the PLL output runs at twice the multiplier times its reference.

A request is launched with a one-cycle `start` while the block is idle. `mode` chooses the direction: 0 encodes `mult_in` and 1 decodes `code_in`. The block steps a 15-bit shift register `LANES` times per cycle until the walk ends. It then runs an 11-step restoring divider for the integral bandwidth rule. Finally it raises `done` for one cycle. The results stay on the outputs until the next request completes.

Top module: `pll_mult_codec`

## Requirements
- R1: Encoding multiplier 0 gives code 0x00000, 1 gives 0x18003 and 2 gives 0x10003; decoding 0x18003 yields 1 and 0x10003 yields 2.
- R2: Encoding a multiplier m in 3..32768 starts from state 0x4000 and takes one step for each count from m up to 32768 inclusive. A step sets the new bit 14 to bit 0 XOR bit 1 of the old state and moves old bits 14:1 into bits 13:0. The resulting state, zero-extended to 17 bits, is the code.
- R3: Decoding any other code starts a counter at 32769 and repeats the following until the state equals 0x4000 or the counter is 0: move the old bits 13:0 into bits 14:1, set the new bit 0 to old bit 0 XOR old bit 14, and decrement the counter. The final counter is the multiplier, so decoding the code of any m in 1..32768 returns m.
- R4: `err` is 1 at `done` for an encode with `mult_in` above 32768, and for a decode whose final counter is 0 (for example code 0) or above 32768 (code 0x4000). It is 0 otherwise.
- R5: `word_out` holds the code in bits 16:0, the proportional field in bits 21:17 and the integral field in bits 27:22. When decoding, the code field repeats `code_in`.
- R6: The proportional field is (m>>1)+1 for m below 60 and 31 otherwise.
- R7: The integral field is 1 for m above 16384, 2 for 8193..16384, 4 for 2049..8192 and 8 for 501..2048.
- R8: For m in 60..500, with t = floor(1024/(m+9)), the integral field is 4(t+1) when m+9 divides 1024 exactly and 4t otherwise.
- R9: For m below 60 the integral field is (m AND 0x3C)+4.
- R10: `start` is taken only while `busy` is 0. `busy` is 1 from the cycle after an accepted start until `done`. `done` is a one-cycle pulse. A `start` given while busy has no effect on the result.
- R11: After reset `busy`, `done`, `err`, `mult_out` and `word_out` are all 0.
- R12: `mult_out` at `done` reports the multiplier: the value of `mult_in` when encoding, and the recovered count when decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a conversion while idle |
| mode | input | 1 | 0 encode, 1 decode |
| mult_in | input | 16 | Binary multiplier to encode |
| code_in | input | 17 | Shift-register code to decode |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Invalid request or code |
| mult_out | output | 16 | Multiplier result |
| word_out | output | 28 | Packed bandwidth fields and code |

## Verification
The bench sweeps a contiguous band of multipliers near 32768 in both directions. It also hits each break of the piecewise bandwidth rules: 59/60, 500/501, 2048/2049, 8192/8193 and 16384/16385, plus 119 and 247, where m+9 divides 1024 exactly. A design with an off-by-one in the walk would return a neighbouring code or count. Misplaced range edges, or a lost exact-division correction, would show up as an integral field one step away from the expected value. The special codes for 1 and 2, a decode that never reaches the seed (code 0), the seed itself, and an out-of-range encode catch a design that walks through the special cases or misses the error. A start pulse sent during a long walk catches a design that restarts mid-conversion.

// File: rtl/pll_mult_codec.sv
module pll_mult_codec #(
  parameter int LANES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode,
  input  logic [15:0] mult_in,
  input  logic [16:0] code_in,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] mult_out,
  output logic [27:0] word_out
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [16:0] MMAX     = 17'd32768;
  localparam logic [16:0] SEED     = 17'h04000;
  localparam logic [16:0] CODE_ONE = 17'h18003;
  localparam logic [16:0] CODE_TWO = 17'h10003;
  localparam logic [16:0] CNT_TOP  = 17'd32769;
  localparam logic [3:0]  DIV_TOP  = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DIV, S_FIN} st_t;

  st_t         st;
  logic        dec_r, err_r;
  logic [16:0] x_r, cnt_r, m_r, code_r;
  logic [15:0] rem_r;
  logic [3:0]  quo_r, bit_r;

  logic [16:0] wx, wc;
  logic        walk_fin;

  always_comb begin
    wx = x_r;
    wc = cnt_r;
    for (int k = 0; k < LANES; k++) begin
      if (!dec_r) begin
        if (wc <= MMAX) begin
          wx = {2'b00, wx[0] ^ wx[1], wx[14:1]};
          wc = wc + 17'd1;
        end
      end else if (wx != SEED && wc != 17'd0) begin
        wx = {2'b00, wx[13:0], wx[0] ^ wx[14]};
        wc = wc - 17'd1;
      end
    end
  end

  assign walk_fin = dec_r ? (wx == SEED || wc == 17'd0) : (wc > MMAX);

  logic [16:0] dv, trial;
  logic        ge;
  assign dv    = m_r + 17'd9;
  assign trial = {rem_r, bit_r == DIV_TOP};
  assign ge    = trial >= dv;

  logic [4:0] selp;
  logic [5:0] seli;
  assign selp = (m_r < 17'd60) ? m_r[5:1] + 5'd1 : 5'd31;

  always_comb begin
    if (m_r > 17'd16384)      seli = 6'd1;
    else if (m_r > 17'd8192)  seli = 6'd2;
    else if (m_r > 17'd2048)  seli = 6'd4;
    else if (m_r >= 17'd501)  seli = 6'd8;
    else if (m_r >= 17'd60)   seli = (rem_r == 16'd0) ? {quo_r + 4'd1, 2'b00} : {quo_r, 2'b00};
    else                      seli = {m_r[5:2], 2'b00} + 6'd4;
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dec_r    <= 1'b0;
      err_r    <= 1'b0;
      x_r      <= '0;
      cnt_r    <= '0;
      m_r      <= '0;
      code_r   <= '0;
      rem_r    <= '0;
      quo_r    <= '0;
      bit_r    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      mult_out <= '0;
      word_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          dec_r <= mode;
          err_r <= 1'b0;
          rem_r <= '0;
          quo_r <= '0;
          bit_r <= DIV_TOP;
          if (!mode) begin
            m_r <= {1'b0, mult_in};
            if (mult_in == 16'd0) begin
              code_r <= '0;
              st     <= S_DIV;
            end else if (mult_in == 16'd1) begin
              code_r <= CODE_ONE;
              st     <= S_DIV;
            end else if (mult_in == 16'd2) begin
              code_r <= CODE_TWO;
              st     <= S_DIV;
            end else if ({1'b0, mult_in} > MMAX) begin
              code_r <= '0;
              err_r  <= 1'b1;
              st     <= S_DIV;
            end else begin
              x_r   <= SEED;
              cnt_r <= {1'b0, mult_in};
              st    <= S_WALK;
            end
          end else begin
            code_r <= code_in;
            x_r    <= code_in;
            if (code_in == CODE_ONE) begin
              m_r <= 17'd1;
              st  <= S_DIV;
            end else if (code_in == CODE_TWO) begin
              m_r <= 17'd2;
              st  <= S_DIV;
            end else begin
              cnt_r <= CNT_TOP;
              st    <= S_WALK;
            end
          end
        end
        S_WALK: begin
          x_r   <= wx;
          cnt_r <= wc;
          if (walk_fin) begin
            if (dec_r) begin
              m_r   <= wc;
              err_r <= (wc == 17'd0) || (wc > MMAX);
            end else begin
              code_r <= wx;
            end
            st <= S_DIV;
          end
        end
        S_DIV: begin
          rem_r <= ge ? 16'(trial - dv) : trial[15:0];
          quo_r <= {quo_r[2:0], ge};
          if (bit_r == 4'd0) st <= S_FIN;
          else               bit_r <= bit_r - 4'd1;
        end
        S_FIN: begin
          done     <= 1'b1;
          err      <= err_r;
          mult_out <= m_r[15:0];
          word_out <= {seli, selp, code_r};
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_mult_codec_chk.sv
module pll_mult_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] mult_out,
  input logic [27:0] word_out
);
  timeunit 1ns; timeprecision 1ps;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(word_out) && $stable(mult_out) && $stable(err)));

  assert_prop_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (word_out[21:17] ==
      ((mult_out < 16'd60) ? (mult_out[5:1] + 5'd1) : 5'd31)));

  assert_one_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && mult_out == 16'd1) |-> (word_out[16:0] == 17'h18003));

  assert_top_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && mult_out > 16'd16384) |-> (word_out[27:22] == 6'd1));

  assert_low_integral_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && mult_out < 16'd60) |->
      (word_out[27:22] == ({mult_out[5:2], 2'b00} + 6'd4)));
endmodule

bind pll_mult_codec pll_mult_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .mult_out(mult_out), .word_out(word_out)
);

// File: tb/tb_pll_mult_codec.sv
module tb_pll_mult_codec;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] mult_in = '0;
  logic [16:0] code_in = '0;
  logic        busy, done, err;
  logic [15:0] mult_out;
  logic [27:0] word_out;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  pll_mult_codec #(.LANES(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mult_in(mult_in),
    .code_in(code_in), .busy(busy), .done(done), .err(err),
    .mult_out(mult_out), .word_out(word_out)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_code(input int m);
    int x;
    if (m == 0) return 0;
    if (m == 1) return 'h18003;
    if (m == 2) return 'h10003;
    x = 'h4000;
    for (int i = m; i <= 32768; i++)
      x = (((x ^ (x >> 1)) & 1) << 14) | (x >> 1);
    return x;
  endfunction

  function automatic int ref_selp(input int m);
    return (m < 60) ? (m / 2) + 1 : 31;
  endfunction

  function automatic int ref_seli(input int m);
    int t;
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60) begin
      t = 1024 / (m + 9);
      return (1024 % (m + 9) == 0) ? 4 * (t + 1) : 4 * t;
    end
    return (m & 'h3C) + 4;
  endfunction

  function automatic string seli_tag(input int m);
    if (m >= 501) return "R7 integral";
    if (m >= 60)  return "R8 integral";
    return "R9 integral";
  endfunction

  task automatic run(input logic md, input int m, input int cd);
    @(negedge clk);
    mode    = md;
    mult_in = 16'(m);
    code_in = 17'(cd);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic check_fields(input int m, input int cd);
    check("R5 code field", longint'(word_out[16:0]), longint'(cd));
    check("R6 proportional", longint'(word_out[21:17]), longint'(ref_selp(m)));
    check(seli_tag(m), longint'(word_out[27:22]), longint'(ref_seli(m)));
    check("R12 mult_out", longint'(mult_out), longint'(m));
    check("R4 no error", longint'(err), 0);
  endtask

  task automatic do_encode(input int m);
    int cd;
    cd = ref_code(m);
    run(1'b0, m, 0);
    if (m <= 2) check("R1 special encode", longint'(word_out[16:0]), longint'(cd));
    else        check("R2 encode walk", longint'(word_out[16:0]), longint'(cd));
    check_fields(m, cd);
  endtask

  task automatic do_decode(input int m);
    int cd;
    cd = ref_code(m);
    run(1'b1, 0, cd);
    if (m <= 2) check("R1 special decode", longint'(mult_out), longint'(m));
    else        check("R3 decode walk", longint'(mult_out), longint'(m));
    check_fields(m, cd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int pts[19] = '{0, 1, 2, 3, 58, 59, 60, 61, 119, 247, 500, 501,
                    2048, 2049, 8192, 8193, 16384, 16385, 32768};
    repeat (3) @(negedge clk);
    check("R11 reset busy", longint'(busy), 0);
    check("R11 reset done", longint'(done), 0);
    check("R11 reset err", longint'(err), 0);
    check("R11 reset word", longint'(word_out), 0);
    check("R11 reset mult", longint'(mult_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    mode = 1'b0; mult_in = 16'd32768; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", longint'(busy), 1);
    while (!done) @(negedge clk);
    check("R10 idle at done", longint'(busy), 0);
    @(negedge clk);
    check("R10 done is a pulse", longint'(done), 0);
    check("R10 outputs held", longint'(word_out[16:0]), longint'(ref_code(32768)));

    foreach (pts[i]) begin
      do_encode(pts[i]);
      if (pts[i] != 0) do_decode(pts[i]);
    end

    for (int m = 32600; m <= 32768; m++) begin
      do_encode(m);
      do_decode(m);
    end

    run(1'b1, 0, 0);
    check("R4 decode of zero errs", longint'(err), 1);
    run(1'b1, 0, 'h4000);
    check("R4 decode of seed errs", longint'(err), 1);
    run(1'b0, 40000, 0);
    check("R4 encode above range errs", longint'(err), 1);
    do_encode(100);

    @(negedge clk);
    mode = 1'b0; mult_in = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    mode = 1'b1; code_in = 17'h18003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R10 start while busy ignored (code)", longint'(word_out[16:0]), longint'(ref_code(3)));
    check("R10 start while busy ignored (mult)", longint'(mult_out), 3);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule